// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block divides a master clock to produce the receive-side TDM bit clock. Each output period lasts either X or X+1 master cycles. A ratio value R, taken over a fixed modulus of 2^N periods, sets how many periods get the extra cycle. The average division factor is therefore X + R/2^N, which is finer than an integer divider can reach.

The choice between a short and a long period comes from an N-bit accumulator. R is added to the accumulator once per period, and an overflow marks that period as long. This spreads the long periods evenly instead of grouping them. A host processor rewrites X and R while the block runs, so the local clock can follow a remote one. The block samples both values only at a period boundary, so it never produces a shortened pulse. Each period starts high and stays high for floor(D/2) master cycles, where D is the length of that period.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst` is high, `clk_out` is low and the period accumulator is cleared to zero.
- R2: With `div_ratio` = 0, every output period (rising edge to rising edge of `clk_out`) lasts exactly X master cycles.
- R3: With N = 4 (modulus 16), any 16 consecutive periods that start at a modulus boundary after reset contain exactly R periods of X+1 cycles, and the others last X cycles.
- R4: Long periods are spread out: counting periods from k = 1 after reset, period k is long exactly when floor(k·R/16) > floor((k−1)·R/16).
- R5: In each period of length D, `clk_out` is high for the first floor(D/2) master cycles and low for the rest.
- R6: Changes to `div_base` or `div_ratio` made after a period has started do not change that period. They take effect from the next period boundary.
- R7: A `div_base` value of 0 or 1 is treated as 2.
- R8: `clk_out` first goes high in the first master cycle after `rst` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| div_base | input | DIV_W | Base divisor X |
| div_ratio | input | ACC_W | Number of long periods in each 2^ACC_W periods |
| clk_out | output | 1 | Divided clock, registered |

## Verification
The hardest case to reach from the ports is a divisor or ratio change that arrives in the middle of a period. A wrong design would apply the change at once and cut the running period short. The stimulus waits until a rising edge of `clk_out` is seen and then changes X and R in the same cycle, so the period already loaded is still in progress. The next two periods are then measured against the old settings and the new settings. The ratio is changed the same way while the accumulator holds a non-zero remainder, so the check also depends on the accumulator being carried over correctly.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  // smallest division factor the counter supports
  localparam int unsigned MIN_DIV = 2;

  typedef enum logic {
    PER_SHORT = 1'b0,
    PER_LONG  = 1'b1
  } per_kind_e;
endpackage

// File: rtl/frac_div_ratio.sv
module frac_div_ratio
  import frac_div_pkg::*;
#(
  parameter int ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [ACC_W-1:0] ratio,
  output per_kind_e        kind
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum  = {1'b0, acc} + {1'b0, ratio};
  assign kind = sum[ACC_W] ? PER_LONG : PER_SHORT;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (step) begin
      acc <= sum[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/frac_div_len.sv
module frac_div_len
  import frac_div_pkg::*;
#(
  parameter int DIV_W = 8,
  localparam int LEN_W = DIV_W + 1
) (
  input  logic [DIV_W-1:0] base,
  input  per_kind_e        kind,
  output logic [LEN_W-1:0] len
);
  logic [DIV_W-1:0] base_eff;

  always_comb begin
    if (base < DIV_W'(MIN_DIV)) base_eff = DIV_W'(MIN_DIV);
    else                        base_eff = base;
    len = LEN_W'(base_eff) + LEN_W'(kind == PER_LONG);
  end
endmodule

// File: rtl/frac_div_gen.sv
module frac_div_gen #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] next_len,
  output logic             boundary,
  output logic [LEN_W-1:0] per_len,
  output logic             clk_out
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] cnt_inc;

  assign boundary = (cnt == per_len - LEN_W'(1));
  assign cnt_inc  = cnt + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      per_len <= LEN_W'(1);
      clk_out <= 1'b0;
    end else if (boundary) begin
      cnt     <= '0;
      per_len <= next_len;
      clk_out <= ((next_len >> 1) != '0);
    end else begin
      cnt     <= cnt_inc;
      clk_out <= (cnt_inc < (per_len >> 1));
    end
  end
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int ACC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_base,
  input  logic [ACC_W-1:0] div_ratio,
  output logic             clk_out
);
  localparam int LEN_W = DIV_W + 1;

  per_kind_e        kind;
  logic [LEN_W-1:0] next_len;
  logic [LEN_W-1:0] per_len;
  logic             boundary;

  frac_div_ratio #(.ACC_W(ACC_W)) u_ratio (
    .clk(clk), .rst(rst), .step(boundary), .ratio(div_ratio), .kind(kind)
  );

  frac_div_len #(.DIV_W(DIV_W)) u_len (
    .base(div_base), .kind(kind), .len(next_len)
  );

  frac_div_gen #(.LEN_W(LEN_W)) u_gen (
    .clk(clk), .rst(rst), .next_len(next_len), .boundary(boundary),
    .per_len(per_len), .clk_out(clk_out)
  );
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int DIV_W = 8,
  parameter int LEN_W = DIV_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [DIV_W-1:0] div_base,
  input logic             clk_out,
  input logic             boundary,
  input logic [LEN_W-1:0] per_len
);
  logic [LEN_W-1:0] eff;
  logic [LEN_W-1:0] hi_run;

  assign eff = (div_base < DIV_W'(2)) ? LEN_W'(2) : LEN_W'(div_base);

  always_ff @(posedge clk) begin
    if (rst)          hi_run <= '0;
    else if (clk_out) hi_run <= hi_run + LEN_W'(1);
    else              hi_run <= '0;
  end

  AST_RST_LOW: assert property (@(posedge clk) rst |=> !clk_out); // R1
  AST_LEN_PICK: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (per_len == $past(eff) || per_len == $past(eff) + LEN_W'(1))); // R3
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(per_len)); // R6
  AST_LEN_MIN: assert property (@(posedge clk) disable iff (rst)
    boundary |=> per_len >= LEN_W'(2)); // R7
  AST_HIGH_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_out) |-> hi_run == (per_len >> 1)); // R5
endmodule

bind frac_clk_div frac_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .div_base(div_base), .clk_out(clk_out),
  .boundary(boundary), .per_len(per_len)
);

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_base = 8'd4;
  logic [3:0] div_ratio = 4'd0;
  logic       clk_out;

  int n_run = 0;
  int n_fail = 0;
  int acc_m = 0;

  frac_clk_div uut (
    .clk(clk), .rst(rst), .div_base(div_base), .div_ratio(div_ratio), .clk_out(clk_out)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int x, input int r);
    @(negedge clk);
    rst = 1'b1; div_base = 8'(x); div_ratio = 4'(r);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(clk_out == 1'b0, "R1 low in reset", int'(clk_out), 0);
    end
    rst = 1'b0;
    acc_m = 0;
    @(negedge clk);
    check(clk_out == 1'b1, "R8 first rise", int'(clk_out), 1);
  endtask

  // measures one period starting at a negedge where clk_out has just risen
  task automatic meas(output int len, output int hi);
    logic prev;
    len = 0; hi = 0; prev = 1'b1;
    for (int g = 0; g < 600; g++) begin
      if (clk_out) hi++;
      len++;
      prev = clk_out;
      @(negedge clk);
      if (clk_out && !prev) return;
    end
  endtask

  function automatic int exp_len(input int x, input int r, output bit lng);
    int eff = (x < 2) ? 2 : x;
    int sum = acc_m + r;
    lng = (sum >= 16);
    acc_m = sum % 16;
    return eff + (lng ? 1 : 0);
  endfunction

  task automatic check_periods(input int x, input int r, input int n, input string req,
                               output int longs);
    int len, hi, e;
    bit lng;
    longs = 0;
    for (int k = 0; k < n; k++) begin
      meas(len, hi);
      e = exp_len(x, r, lng);
      if (lng) longs++;
      check(len == e, req, len, e);
      check(hi == e / 2, "R5 high span", hi, e / 2);
    end
  endtask

  task automatic t_integer();
    int longs;
    do_reset(5, 0);
    check_periods(5, 0, 6, "R2 integer x5", longs);
    do_reset(6, 0);
    check_periods(6, 0, 4, "R2 integer x6", longs);
  endtask

  task automatic t_ratio(input int x, input int r);
    int longs;
    do_reset(x, r);
    check_periods(x, r, 16, "R4 spread", longs);
    check(longs == r, "R3 long count", longs, r);
  endtask

  task automatic t_clamp();
    int longs;
    do_reset(0, 0);
    check_periods(0, 0, 3, "R7 clamp x0", longs);
    do_reset(1, 0);
    check_periods(1, 0, 3, "R7 clamp x1", longs);
    do_reset(1, 8);
    check_periods(1, 8, 4, "R7 clamp x1 r8", longs);
  endtask

  task automatic t_change();
    int len, hi, e;
    bit lng;
    do_reset(8, 0);
    div_base = 8'd4;            // change while first period runs
    meas(len, hi); e = exp_len(8, 0, lng);
    check(len == e, "R6 old x kept", len, e);
    div_ratio = 4'd8;           // ratio change while period runs
    meas(len, hi); e = exp_len(4, 0, lng);
    check(len == e, "R6 old r kept", len, e);
    for (int k = 0; k < 4; k++) begin
      meas(len, hi); e = exp_len(4, 8, lng);
      check(len == e, "R6 new settings", len, e);
    end
    // change with a non-zero remainder in the accumulator
    div_ratio = 4'd3; div_base = 8'd7;
    meas(len, hi); e = exp_len(4, 8, lng);
    check(len == e, "R6 mid remainder", len, e);
    for (int k = 0; k < 6; k++) begin
      meas(len, hi); e = exp_len(7, 3, lng);
      check(len == e, "R6 after remainder", len, e);
    end
  endtask

  initial begin
    t_integer();
    t_ratio(6, 4);
    t_ratio(3, 15);
    t_ratio(2, 1);
    t_ratio(9, 7);
    t_clamp();
    t_change();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule